// File: doc/BRIEF.md
# Oversampling Serial Receiver with Ninth-Bit Capture

This block recovers characters from an asynchronous serial line that idles high. It divides the system clock by a programmable amount to make a sample tick, sees sixteen ticks in every bit period, and decides each bit from three samples taken around the middle of that bit. A character is a low start bit, then eight or nine data bits with the least significant bit first, then a stop bit. In nine-bit mode the last data bit goes to its own output, so that it can serve as an address marker, a parity bit or a second stop bit.

A single holding register passes each finished character to the reader, with a done flag that the reader clears by pulsing a read strobe. The block also raises a flag when a character arrives before the previous one has been read, and another when a stop bit is found low. Both flags can only be set while the receiver is enabled. Turning the receiver off stops reception at once but leaves every flag and the held character as they were.

Top module: `uart_rx_unit`

## Requirements
- R1: While reset is asserted and right after it is released, `rxData` is 0 and `rxBit8`, `rxDone`, `overrunFlag` and `frameErr` are all 0.
- R2: The sample tick comes once every `divisor`+1 clock cycles and each bit lasts 16 ticks. When a stop bit is high and the holding register is free, an eight-bit character (least significant bit first) is loaded into `rxData`, `rxDone` is set and `rxBit8` is 0.
- R3: When `nineBitMode` is 1 at the start of a character, nine data bits are received: the first eight go to `rxData` and the ninth goes to `rxBit8`.
- R4: Each bit takes the majority value of samples 7, 8 and 9 (the edge tick is sample 0). A disturbance that lasts one tick and falls on one of those samples does not change the received value.
- R5: The start bit is checked by the same vote. If the vote finds the line high, the receiver goes back to idle, loads nothing, and then accepts the next character normally.
- R6: A stop bit voted low loads the character as usual and sets `frameErr`.
- R7: A one-cycle pulse on `readStrobe` clears `rxDone`. If a read and a completion happen in the same cycle, the read takes effect first.
- R8: If a character completes while `rxDone` is still set, `overrunFlag` is set, and `rxData`, `rxBit8` and `frameErr` keep the unread character.
- R9: `overrunFlag` and `frameErr` change only when a character completes. A read leaves them as they are. Each load into the holding register clears `overrunFlag` and sets `frameErr` from that character's stop bit.
- R10: While `rxEnable` is 0, nothing is received, and neither `rxDone`, `overrunFlag` nor `frameErr` can become set.
- R11: Clearing `rxEnable` leaves `rxDone`, `overrunFlag`, `frameErr` and the held character unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| rxLine | input | 1 | Serial input, idles high |
| rxEnable | input | 1 | Receiver on when 1 |
| nineBitMode | input | 1 | 1 selects nine data bits |
| divisor | input | DIV_W (8) | Sample tick every divisor+1 clocks |
| readStrobe | input | 1 | One-cycle read of the held character |
| rxData | output | DATA_W (8) | Held character, low eight data bits |
| rxBit8 | output | 1 | Ninth data bit of the held character |
| rxDone | output | 1 | Unread character present |
| overrunFlag | output | 1 | A character was lost to an unread one |
| frameErr | output | 1 | Held character had a low stop bit |

## Verification
The bench keeps the default parameters: an eight-bit base width, an eight-bit divider and sixteen samples per bit. At run time it sets the divisor to 3, which gives 64 clocks per bit, so a glitch one tick wide and a false start a few ticks long can be placed inside a bit. It also sets the divisor to 0, where a tick comes on every clock and the divider counter never counts. Frames stay short enough that the overrun and sticky-flag cases, which need two frames in a row each, fit in a short run.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;  // take one vote sample
    logic shift;    // push voted data bit into the shifter
    logic commit;   // stop bit decided, finish character
    logic nineBit;  // character carries nine data bits
  } rxStrobe_t;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP
  } rxState_t;

endpackage

// File: rtl/uart_rx_ticker.sv
module uart_rx_ticker #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic [DIV_W-1:0] divisor,
  output logic             tick
);

  logic [DIV_W-1:0] divCnt;
  logic             wrapNow;

  // compare with >= so a smaller divisor written mid-count takes effect at once
  assign wrapNow = (divCnt >= divisor);
  assign tick    = enable && wrapNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= '0;
    end else if (!enable || wrapNow) begin
      divCnt <= '0;
    end else begin
      divCnt <= divCnt + DIV_W'(1);
    end
  end

endmodule

// File: rtl/uart_rx_ctrl.sv
module uart_rx_ctrl
  import uart_rx_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int OVERSAMPLE = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       tick,
  input  logic       nineMode,
  input  logic       lineNow,
  input  logic       voteBit,
  output rxStrobe_t  strobe
);

  localparam int CNT_W   = $clog2(OVERSAMPLE);
  localparam int MID     = OVERSAMPLE / 2;
  localparam int VOTE_LO = MID - 1;
  localparam int VOTE_HI = MID + 1;
  localparam int DECIDE  = MID + 2;
  localparam int LAST    = OVERSAMPLE - 1;
  localparam int BIT_W   = $clog2(DATA_W + 1);

  rxState_t         state;
  logic [CNT_W-1:0] sampleCnt;
  logic [BIT_W-1:0] bitCnt;
  logic [BIT_W-1:0] lastBit;
  logic             prevLine;
  logic             nineLatch;
  logic             atDecide;
  logic             atLast;
  logic             inVote;

  assign atDecide = tick && (sampleCnt == CNT_W'(DECIDE));
  assign atLast   = (sampleCnt == CNT_W'(LAST));
  assign inVote   = (sampleCnt >= CNT_W'(VOTE_LO)) && (sampleCnt <= CNT_W'(VOTE_HI));
  assign lastBit  = nineLatch ? BIT_W'(DATA_W) : BIT_W'(DATA_W - 1);

  always_comb begin
    strobe         = '0;
    strobe.capture = tick && (state != RX_IDLE) && inVote;
    strobe.shift   = atDecide && (state == RX_DATA);
    strobe.commit  = atDecide && (state == RX_STOP);
    strobe.nineBit = nineLatch;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= RX_IDLE;
      sampleCnt <= '0;
      bitCnt    <= '0;
      prevLine  <= 1'b1;
      nineLatch <= 1'b0;
    end else if (!enable) begin
      state     <= RX_IDLE;
      sampleCnt <= '0;
      bitCnt    <= '0;
      prevLine  <= 1'b1;
    end else if (tick) begin
      prevLine <= lineNow;
      if (state == RX_IDLE) begin
        if (prevLine && !lineNow) begin
          state     <= RX_START;
          sampleCnt <= CNT_W'(1);
          bitCnt    <= '0;
          nineLatch <= nineMode;
        end
      end else if (atDecide && ((state == RX_START && voteBit) || state == RX_STOP)) begin
        // false start, or stop bit decided early to catch the next edge
        state     <= RX_IDLE;
        sampleCnt <= '0;
      end else begin
        sampleCnt <= atLast ? '0 : sampleCnt + CNT_W'(1);
        if (atLast) begin
          if (state == RX_START) begin
            state  <= RX_DATA;
            bitCnt <= '0;
          end else if (state == RX_DATA) begin
            if (bitCnt == lastBit) state <= RX_STOP;
            else bitCnt <= bitCnt + BIT_W'(1);
          end
        end
      end
    end
  end

endmodule

// File: rtl/uart_rx_dpath.sv
module uart_rx_dpath
  import uart_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxLine,
  input  logic              readStrobe,
  input  rxStrobe_t         strobe,
  output logic              lineNow,
  output logic              voteBit,
  output logic [DATA_W-1:0] rxData,
  output logic              rxBit8,
  output logic              rxDone,
  output logic              overrunFlag,
  output logic              frameErr
);

  localparam int SH_W = DATA_W + 1;

  logic [1:0]      syncReg;
  logic [2:0]      votes;
  logic [SH_W-1:0] shifter;
  logic            holdBusy;

  assign lineNow  = syncReg[1];
  assign voteBit  = (votes[0] & votes[1]) | (votes[0] & votes[2]) | (votes[1] & votes[2]);
  assign holdBusy = rxDone && !readStrobe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncReg <= 2'b11;
      votes   <= 3'b111;
      shifter <= '0;
    end else begin
      syncReg <= {syncReg[0], rxLine};
      if (strobe.capture) votes <= {votes[1:0], lineNow};
      if (strobe.shift) shifter <= {voteBit, shifter[SH_W-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxData      <= '0;
      rxBit8      <= 1'b0;
      rxDone      <= 1'b0;
      overrunFlag <= 1'b0;
      frameErr    <= 1'b0;
    end else if (strobe.commit) begin
      if (holdBusy) begin
        overrunFlag <= 1'b1;
      end else begin
        rxData      <= strobe.nineBit ? shifter[DATA_W-1:0] : shifter[SH_W-1:1];
        rxBit8      <= strobe.nineBit & shifter[SH_W-1];
        rxDone      <= 1'b1;
        overrunFlag <= 1'b0;
        frameErr    <= ~voteBit;
      end
    end else if (readStrobe) begin
      rxDone <= 1'b0;
    end
  end

endmodule

// File: rtl/uart_rx_unit.sv
module uart_rx_unit
  import uart_rx_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int DIV_W      = 8,
  parameter int OVERSAMPLE = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxLine,
  input  logic              rxEnable,
  input  logic              nineBitMode,
  input  logic [DIV_W-1:0]  divisor,
  input  logic              readStrobe,
  output logic [DATA_W-1:0] rxData,
  output logic              rxBit8,
  output logic              rxDone,
  output logic              overrunFlag,
  output logic              frameErr
);

  rxStrobe_t strobe;
  logic      tick;
  logic      lineNow;
  logic      voteBit;
  logic      commitNow;

  assign commitNow = strobe.commit;

  uart_rx_ticker #(.DIV_W(DIV_W)) ticker (
    .clk(clk), .rstN(rstN), .enable(rxEnable), .divisor(divisor), .tick(tick)
  );

  uart_rx_ctrl #(.DATA_W(DATA_W), .OVERSAMPLE(OVERSAMPLE)) ctrl (
    .clk(clk), .rstN(rstN), .enable(rxEnable), .tick(tick), .nineMode(nineBitMode),
    .lineNow(lineNow), .voteBit(voteBit), .strobe(strobe)
  );

  uart_rx_dpath #(.DATA_W(DATA_W)) dpath (
    .clk(clk), .rstN(rstN), .rxLine(rxLine), .readStrobe(readStrobe), .strobe(strobe),
    .lineNow(lineNow), .voteBit(voteBit), .rxData(rxData), .rxBit8(rxBit8),
    .rxDone(rxDone), .overrunFlag(overrunFlag), .frameErr(frameErr)
  );

endmodule

// File: rtl/uart_rx_unit_chk.sv
module uart_rx_unit_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              rxEnable,
  input logic              readStrobe,
  input logic              commitNow,
  input logic [DATA_W-1:0] rxData,
  input logic              rxDone,
  input logic              overrunFlag,
  input logic              frameErr
);

  // R7
  read_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    (readStrobe && !commitNow) |=> !rxDone);

  // R8
  overrun_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (commitNow && rxDone && !readStrobe) |=> (overrunFlag && $stable(rxData) && $stable(frameErr)));

  // R9
  load_clears_ovr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (commitNow && (!rxDone || readStrobe)) |=> (rxDone && !overrunFlag));

  // R9
  flags_only_on_commit_chk: assert property (@(posedge clk) disable iff (!rstN)
    !commitNow |=> ($stable(overrunFlag) && $stable(frameErr)));

  // R10
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rxEnable |=> ($stable(overrunFlag) && $stable(frameErr) && !$rose(rxDone)));

  // R2
  done_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxDone) |-> $past(commitNow));

endmodule

bind uart_rx_unit uart_rx_unit_chk #(.DATA_W(DATA_W)) chkInst (
  .clk(clk), .rstN(rstN), .rxEnable(rxEnable), .readStrobe(readStrobe),
  .commitNow(commitNow), .rxData(rxData), .rxDone(rxDone),
  .overrunFlag(overrunFlag), .frameErr(frameErr)
);

// File: tb/uart_rx_unit_test.sv
module uart_rx_unit_test;

  logic       clk = 1'b0;
  logic       rstN;
  logic       rxLine;
  logic       rxEnable;
  logic       nineBitMode;
  logic [7:0] divisor;
  logic       readStrobe;
  logic [7:0] rxData;
  logic       rxBit8;
  logic       rxDone;
  logic       overrunFlag;
  logic       frameErr;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  uart_rx_unit uut (
    .clk(clk), .rstN(rstN), .rxLine(rxLine), .rxEnable(rxEnable),
    .nineBitMode(nineBitMode), .divisor(divisor), .readStrobe(readStrobe),
    .rxData(rxData), .rxBit8(rxBit8), .rxDone(rxDone),
    .overrunFlag(overrunFlag), .frameErr(frameErr)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  function automatic int tickClks();
    return int'(divisor) + 1;
  endfunction

  task automatic holdTicks(input int n);
    repeat (n * tickClks()) @(negedge clk);
  endtask

  task automatic sendFrame(input logic [8:0] val, input bit nine, input logic stopVal);
    rxLine = 1'b0;
    holdTicks(16);
    for (int i = 0; i < (nine ? 9 : 8); i++) begin
      rxLine = val[i];
      holdTicks(16);
    end
    rxLine = stopVal;
    holdTicks(16);
    rxLine = 1'b1;
    holdTicks(16);
  endtask

  task automatic doRead();
    @(negedge clk) readStrobe = 1'b1;
    @(negedge clk) readStrobe = 1'b0;
  endtask

  task automatic testReset();
    check("R1 data", rxData, 0);
    check("R1 done", rxDone, 0);
    check("R1 ovr", overrunFlag, 0);
    check("R1 ferr", frameErr, 0);
    check("R1 bit8", rxBit8, 0);
  endtask

  task automatic testBasic();
    sendFrame(9'h0A5, 0, 1'b1);
    check("R2 data", rxData, 8'hA5);
    check("R2 done", rxDone, 1);
    check("R2 bit8", rxBit8, 0);
    check("R6 ferr clear", frameErr, 0);
    doRead();
    check("R7 read clears done", rxDone, 0);
  endtask

  task automatic testNine();
    nineBitMode = 1'b1;
    sendFrame(9'h13C, 1, 1'b1);
    check("R3 data", rxData, 8'h3C);
    check("R3 bit8 one", rxBit8, 1);
    doRead();
    sendFrame(9'h0C3, 1, 1'b1);
    check("R3 data b", rxData, 8'hC3);
    check("R3 bit8 zero", rxBit8, 0);
    doRead();
    nineBitMode = 1'b0;
  endtask

  task automatic testFraming();
    sendFrame(9'h066, 0, 1'b0);
    check("R6 data", rxData, 8'h66);
    check("R6 done", rxDone, 1);
    check("R6 ferr set", frameErr, 1);
    doRead();
    check("R9 ferr kept on read", frameErr, 1);
    sendFrame(9'h099, 0, 1'b1);
    check("R9 ferr follows next", frameErr, 0);
    check("R9 data", rxData, 8'h99);
    doRead();
  endtask

  task automatic testOverrun();
    sendFrame(9'h011, 0, 1'b1);
    sendFrame(9'h022, 0, 1'b1);
    check("R8 ovr set", overrunFlag, 1);
    check("R8 data kept", rxData, 8'h11);
    check("R8 done", rxDone, 1);
    doRead();
    check("R9 ovr kept on read", overrunFlag, 1);
    sendFrame(9'h033, 0, 1'b1);
    check("R9 ovr cleared", overrunFlag, 0);
    check("R9 data new", rxData, 8'h33);
    doRead();
  endtask

  task automatic testFalseStart();
    rxLine = 1'b0;
    holdTicks(4);
    rxLine = 1'b1;
    holdTicks(32);
    check("R5 no char", rxDone, 0);
    sendFrame(9'h05A, 0, 1'b1);
    check("R5 next char", rxData, 8'h5A);
    doRead();
  endtask

  task automatic testGlitch();
    logic [7:0] val = 8'hF0;
    rxLine = 1'b0;
    holdTicks(16);
    for (int i = 0; i < 8; i++) begin
      rxLine = val[i];
      if (i == 2) begin
        holdTicks(8);
        rxLine = ~val[i];
        holdTicks(1);
        rxLine = val[i];
        holdTicks(7);
      end else begin
        holdTicks(16);
      end
    end
    rxLine = 1'b1;
    holdTicks(32);
    check("R4 majority", rxData, 8'hF0);
    doRead();
  endtask

  task automatic testDisabled();
    rxEnable = 1'b0;
    sendFrame(9'h077, 0, 1'b0);
    check("R10 done", rxDone, 0);
    check("R10 ferr", frameErr, 0);
    check("R10 ovr", overrunFlag, 0);
    rxEnable = 1'b1;
    holdTicks(16);
    sendFrame(9'h044, 0, 1'b1);
    check("R10 resume", rxData, 8'h44);
    doRead();
  endtask

  task automatic testSticky();
    sendFrame(9'h012, 0, 1'b0);
    sendFrame(9'h034, 0, 1'b1);
    rxEnable = 1'b0;
    holdTicks(32);
    check("R11 ovr", overrunFlag, 1);
    check("R11 ferr", frameErr, 1);
    check("R11 done", rxDone, 1);
    check("R11 data", rxData, 8'h12);
    rxEnable = 1'b1;
    doRead();
    holdTicks(16);
    sendFrame(9'h056, 0, 1'b1);
    check("R9 after sticky", {overrunFlag, frameErr}, 2'b00);
    check("R9 data after sticky", rxData, 8'h56);
    doRead();
  endtask

  task automatic testFastDivisor();
    divisor = 8'd0;
    holdTicks(16);
    sendFrame(9'h0C9, 0, 1'b1);
    check("R2 divisor zero", rxData, 8'hC9);
    check("R2 divisor zero done", rxDone, 1);
    doRead();
    divisor = 8'd3;
  endtask

  initial begin
    rstN        = 1'b0;
    rxLine      = 1'b1;
    rxEnable    = 1'b1;
    nineBitMode = 1'b0;
    divisor     = 8'd3;
    readStrobe  = 1'b0;
    repeat (4) @(negedge clk);
    testReset();
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    testReset();
    holdTicks(16);
    testBasic();
    testNine();
    testFraming();
    testOverrun();
    testFalseStart();
    testGlitch();
    testDisabled();
    testSticky();
    testFastDivisor();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog R2 actual=timeout expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule